// File: doc/BRIEF.md
# Reloading Up-Counting Interval Timer

This block is an interval timer with a count register that counts upward. A fixed prescaler divides the input clock so that the count register advances once every few clock cycles. When the count passes its all-ones value it does not wrap to zero. Instead, it reloads from a reload register that software writes one byte at a time. The same event sets a sticky timeout flag, and that flag also drives an interrupt output.

Software programs the interval by writing the low and high bytes of the reload register. The remaining time is the distance from the current count to the wrap point. A write to the reload register never disturbs the running count; the new value takes effect at the next wrap. The live count can be read as two byte-wide outputs at any time. Software acknowledges a timeout through a clear input. If a new wrap occurs in the same cycle as the clear, the flag stays set, so no timeout is lost.

The count width is a parameter (9 to 16 bits, 16 by default). The prescale ratio is also a parameter (4 by default).

Top module: `sys_tick_timer`

## Requirements
- R1: While reset is asserted and after it is released, the count, the reload register and the prescaler are all zero. `tmo_flag` and `irq` are 0 until the first wrap.
- R2: The count changes only on every PRESCALE-th rising clock edge after reset is released; with the default of 4, the first change is at the 4th edge. At every other edge the count holds its value. When the count is below all ones it advances by exactly one.
- R3: A cycle with `wr_lo` high loads `wr_data` into reload bits 7:0. A cycle with `wr_hi` high loads `wr_data[CNT_W-9:0]` into reload bits CNT_W-1:8. Neither write changes the running count.
- R4: On a counting edge where the count is all ones, the count is loaded with the reload value. It does not become zero unless the reload value is zero.
- R5: The edge that performs the reload of R4 sets `tmo_flag`. `irq` always equals `tmo_flag`.
- R6: `tmo_flag` stays set until a cycle with `tmo_clr` high. If a wrap occurs in that same cycle, the flag remains set, because setting wins over clearing.
- R7: `rd_lo` shows count bits 7:0. `rd_hi` shows count bits CNT_W-1:8, zero-extended to 8 bits.
- R8: A reload-register write in the same cycle as a wrap does not affect that wrap, which uses the value held before the edge. The newly written value is used at the following wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 8 | Byte written to the reload register |
| wr_lo | input | 1 | Write strobe for the reload low byte |
| wr_hi | input | 1 | Write strobe for the reload high byte |
| tmo_clr | input | 1 | Clear request for the timeout flag |
| rd_lo | output | 8 | Count bits 7:0 |
| rd_hi | output | 8 | Count upper bits, zero-extended |
| tmo_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request, equal to the flag |

## Verification
Properties next to the logic check the following on every cycle:
- the prescaler never produces two counting edges in a row;
- the count holds between counting edges and steps by one below all ones;
- a wrap loads the reload value;
- reload bytes land in their fields;
- the flag sets, clears and holds as required.

Some behaviour only the bench scenarios can show:
- the exact edge of the first count after reset;
- that reload writes leave the count untouched at the ports;
- that a write coinciding with a wrap is deferred to the next wrap;
- that setting wins over a simultaneous clear.

The bench checks these against a cycle model built from the requirements, on a reduced 10-bit count that wraps many times.

// File: rtl/sys_tmr_pkg.sv
package sys_tmr_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              sel_lo;
        logic              sel_hi;
        logic [BYTE_W-1:0] data;
    } lat_wr_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pre == LAST) st_d.pre = '0;
        else                  st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = (st_q.pre == LAST);

    // Two counting edges never occur back to back (R2).
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_latch.sv
module tmr_latch
    import sys_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lat_wr_t          wr_i,
    output logic [CNT_W-1:0] lat_o
);
    localparam int HI_W = CNT_W - BYTE_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] lo;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i.sel_lo) st_d.lo = wr_i.data;
        if (wr_i.sel_hi) st_d.hi = wr_i.data[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_o = {st_q.hi, st_q.lo};

    p_lo_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.sel_lo |=> lat_o[BYTE_W-1:0] == $past(wr_i.data));
    p_hi_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.sel_hi |=> lat_o[CNT_W-1:BYTE_W] == $past(wr_i.data[HI_W-1:0]));
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i.sel_lo && !wr_i.sel_hi) |=> $stable(lat_o));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] lat_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign wrap_o = tick_i && (st_q.cnt == ALL_ONES);

    always_comb begin
        st_d = st_q;
        if (wrap_o)      st_d.cnt = lat_i;
        else if (tick_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_o != ALL_ONES) |=> cnt_o == $past(cnt_o) + 1'b1);
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_o == ALL_ONES) |=> cnt_o == $past(lat_i));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import sys_tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              tmo_clr,
    output logic [BYTE_W-1:0] rd_lo,
    output logic [BYTE_W-1:0] rd_hi,
    output logic              tmo_flag,
    output logic              irq
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] lat;
    logic [CNT_W-1:0] cnt;
    lat_wr_t          wr;

    assign wr = '{sel_lo: wr_lo, sel_hi: wr_hi, data: wr_data};

    tmr_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tmr_latch #(.CNT_W(CNT_W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (wr),
        .lat_o (lat)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .lat_i  (lat),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    tmr_flag u_flg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wrap),
        .clr_i  (tmo_clr),
        .flag_o (tmo_flag)
    );

    assign rd_lo = cnt[BYTE_W-1:0];
    generate
        if (HI_W == BYTE_W) begin : g_full_hi
            assign rd_hi = cnt[CNT_W-1:BYTE_W];
        end else begin : g_pad_hi
            assign rd_hi = {{(BYTE_W-HI_W){1'b0}}, cnt[CNT_W-1:BYTE_W]};
        end
    endgenerate

    assign irq = tmo_flag;

    // A wrap raises the interrupt on the next cycle (R5).
    p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> irq);
endmodule

// File: tb/sys_tick_timer_test.sv
module sys_tick_timer_test;
    localparam int CLK_PER = 10;
    localparam int CW      = 10;
    localparam int PS      = 4;
    localparam int MAXV    = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic       tmo_clr = 1'b0;
    logic [7:0] rd_lo, rd_hi;
    logic       tmo_flag, irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;

    // Requirement-level cycle model
    int m_pre = 0, m_cnt = 0, m_lat = 0;
    bit m_flag = 1'b0;

    sys_tick_timer #(.CNT_W(CW), .PRESCALE(PS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .tmo_clr(tmo_clr), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .tmo_flag(tmo_flag), .irq(irq)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int dut_cnt();
        return {rd_hi[CW-9:0], rd_lo};
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        bit roll;
        int old_lat;
        cyc++;
        old_lat = m_lat;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_lat = 0; m_flag = 1'b0;
        end else begin
            roll = 1'b0;
            if (wr_lo) m_lat = (m_lat & ~8'hFF) | int'(wr_data);
            if (wr_hi) m_lat = (m_lat & 8'hFF) | ((int'(wr_data) & ((1 << (CW-8)) - 1)) << 8);
            if (m_pre == PS - 1) begin
                m_pre = 0;
                if (m_cnt == MAXV) begin
                    m_cnt = old_lat;   // R8: value held before the edge
                    roll = 1'b1;
                end else m_cnt = m_cnt + 1;
            end else m_pre = m_pre + 1;
            if (roll) m_flag = 1'b1;
            else if (tmo_clr) m_flag = 1'b0;
        end
    end

    // Per-cycle comparison against the model (R2, R4, R5, R6, R7)
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2/R4 count", dut_cnt(), m_cnt);
            chk("R7 hi pad", int'(rd_hi >> (CW-8)), 0);
            chk("R5/R6 flag", int'(tmo_flag), int'(m_flag));
            chk("R5 irq", int'(irq), int'(tmo_flag));
        end
    end

    always @(negedge clk) begin
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
            finish_run();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        int t0;
        idle(3);
        // R1: values during reset
        chk("R1 count in reset", dut_cnt(), 0);
        chk("R1 flag in reset", int'(tmo_flag), 0);
        rst_n = 1'b1;
        // R2: first increment on the 4th edge after release
        idle(3);
        chk("R2 hold before 4th edge", dut_cnt(), 0);
        idle(1);
        chk("R2 first step at 4th edge", dut_cnt(), 1);
        cmp_en = 1'b1;
        // R2: arithmetic sweep of 100 periods
        idle(PS * 100);
        chk("R2 after 101 periods", dut_cnt(), 101);
        chk("R1 no flag before wrap", int'(irq), 0);

        // R3: latch write leaves the count untouched
        base = dut_cnt();
        wr_data = 8'hF0; wr_lo = 1'b1; @(negedge clk);
        wr_lo = 1'b0; wr_data = 8'h03; wr_hi = 1'b1; @(negedge clk);
        wr_hi = 1'b0;
        chk("R3 count unaffected by writes", dut_cnt() - base, (dut_cnt() == base) ? 0 : 1);

        // R4, R5: run to the first wrap
        t0 = cyc;
        while (!tmo_flag && cyc - t0 < 8000) @(negedge clk);
        chk("R5 flag after first wrap", int'(tmo_flag), 1);
        chk("R4 reload value", dut_cnt(), 16'h3F0);

        // R6: sticky, then clear
        idle(20);
        chk("R6 flag sticky", int'(tmo_flag), 1);
        tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
        chk("R6 cleared", int'(tmo_flag), 0);

        // R6 + R8: clear and latch write in the cycle of a wrap
        for (int k = 0; k < 3; k++) begin
            t0 = cyc;
            while (!(m_pre == PS - 1 && m_cnt == MAXV) && cyc - t0 < 8000) @(negedge clk);
            tmo_clr = 1'b1;
            wr_data = 8'h00 + 8'(k); wr_hi = 1'b1;
            wr_lo = 1'b1;
            @(negedge clk);
            tmo_clr = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
            chk("R6 set beats clear", int'(tmo_flag), 1);
            chk("R8 wrap uses old reload", dut_cnt(), (k == 0) ? 16'h3F0 : ((k - 1) << 8) | (k - 1));
            tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
        end
        // R8: next wrap uses the value written last
        t0 = cyc;
        while (!tmo_flag && cyc - t0 < 8000) @(negedge clk);
        chk("R8 new reload at next wrap", dut_cnt(), (2 << 8) | 2);

        // R1: reset in mid-run clears everything
        rst_n = 1'b0; idle(2);
        chk("R1 count after reset", dut_cnt(), 0);
        chk("R1 flag after reset", int'(irq), 0);
        rst_n = 1'b1;
        idle(PS * (MAXV + 1) + 2);
        chk("R1 reload cleared by reset", int'(tmo_flag), 1);
        finish_run();
    end
endmodule